// File: doc/BRIEF.md
# Rotating Register File Remapper

This block is an integer register file for software-pipelined loops. It holds 128 entries. Each entry has a 64-bit data word and a one-bit deferred-exception tag. Every logical register number on a port is translated to a physical entry before the access.

The bottom 32 numbers are static and map straight through. Register 0 is hard-wired to zero. The remaining 96 numbers form a rotating window. Their physical entry is found by adding the logical offset to a rename base, modulo the window size.

Each loop rotation moves the base down by one. A value written to logical X therefore comes back through logical X+1, and the top register wraps to the bottom of the window. The block has two combinational read ports and one clocked write port. It also has a rotate strobe and a base-clear input.

Top module: `rot_regfile`

## Requirements
- R1: After reset every entry reads as data 0 with tag 0, and the rename base is 0, so every logical number reaches its own physical entry.
- R2: Logical registers 1 to 31 always reach the same entry, whatever the rename base, and are unaffected by rotation.
- R3: Logical register 0 always reads data 0 and tag 0 on both ports. A write to it is discarded.
- R4: The tag bit is written and read together with the data word. The tag is output rdNatA or rdNatB, alongside the 64 data bits.
- R5: A value written to logical X in 32..126, followed by one rotate pulse, reads back through logical X+1.
- R6: After one rotation, a value written to logical 127 reads back through logical 32.
- R7: After k rotations, a value written at X reads back at 32 + ((X - 32 + k) mod 96). After 96 rotations the mapping is the original one again.
- R8: A clearBase pulse sets the rename base to 0, so a value written at base 0 reads back at its original logical number. clearBase wins over a rotate in the same cycle.
- R9: When a write and a rotate fall in the same cycle, the write uses the base from before the rotation.
- R10: In the write cycle, a read of the entry being written returns the old contents. The new contents appear from the next cycle.
- R11: The two read ports are independent and can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdIdxA | input | 7 | Logical register number, read port A |
| rdDataA | output | 64 | Data, read port A |
| rdNatA | output | 1 | Deferred-exception tag, read port A |
| rdIdxB | input | 7 | Logical register number, read port B |
| rdDataB | output | 64 | Data, read port B |
| rdNatB | output | 1 | Deferred-exception tag, read port B |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 7 | Logical register number for the write |
| wrData | input | 64 | Write data |
| wrNat | input | 1 | Write tag |
| rotate | input | 1 | Rotation strobe: decrements the rename base |
| clearBase | input | 1 | Resets the rename base to 0 |

## Verification
A wrong rename base stays invisible until a rotating register is read after a rotation. At that read it shows up as data read back from a neighbouring logical number, or as the wrong number at the wrap point. Each such fault is therefore caught on the first read after the rotation in which the base went wrong.

A mapping fault in the static range, or in register 0, shows up immediately as a mismatch against an index that should not move. A timing fault in the write path shows up on the read just before or just after the write edge. Such faults include using the post-rotation base, or forwarding new data early.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  typedef struct packed {
    logic wrFire;
    logic rotFire;
    logic clrFire;
  } ctrlStrobe_t;
endpackage

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ROT_N  = NUM_REGS - NUM_STATIC,
  localparam int BASE_W = $clog2(ROT_N)
) (
  input  logic [IDX_W-1:0]  logIdx,
  input  logic [BASE_W-1:0] base,
  output logic [IDX_W-1:0]  physIdx
);
  localparam int SUM_W = BASE_W + 1;

  logic [SUM_W-1:0] offset;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    offset  = SUM_W'(logIdx - IDX_W'(NUM_STATIC));
    sum     = offset + SUM_W'(base);
    wrapped = (sum >= SUM_W'(ROT_N)) ? sum - SUM_W'(ROT_N) : sum;
    if (logIdx < IDX_W'(NUM_STATIC)) physIdx = logIdx;
    else                             physIdx = IDX_W'(wrapped) + IDX_W'(NUM_STATIC);
  end

  always_comb begin
    if (!$isunknown(logIdx) && !$isunknown(base)) begin
      if (logIdx < IDX_W'(NUM_STATIC)) begin
        a_r2_static_identity: assert (physIdx == logIdx);
      end else begin
        a_r6_stays_in_window: assert (physIdx >= IDX_W'(NUM_STATIC));
      end
    end
  end
endmodule

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
#(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ROT_N  = NUM_REGS - NUM_STATIC,
  localparam int BASE_W = $clog2(ROT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              rotate,
  input  logic              clearBase,
  output ctrlStrobe_t       strobe,
  output logic [BASE_W-1:0] base
);
  always_comb begin
    strobe.wrFire  = wrEn && (wrIdx != '0);
    strobe.clrFire = clearBase;
    strobe.rotFire = rotate && !clearBase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              base <= '0;
    else if (strobe.clrFire) base <= '0;
    else if (strobe.rotFire) base <= (base == '0) ? BASE_W'(ROT_N - 1) : base - BASE_W'(1);
  end

  a_r7_base_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(base) < ROT_N);

  a_r8_clear_base: assert property (@(posedge clk) disable iff (!rst_n)
    clearBase |=> base == '0);

  a_r5_rotate_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !clearBase) |=> !$stable(base));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && !clearBase) |=> $stable(base));
endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath
  import rrf_pkg::*;
#(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  parameter int DATA_W     = 64,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ROT_N  = NUM_REGS - NUM_STATIC,
  localparam int BASE_W = $clog2(ROT_N),
  localparam int WORD_W = DATA_W + 1,
  localparam int NPORT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [BASE_W-1:0] base,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrWord,
  output logic [WORD_W-1:0] rdWordA,
  output logic [WORD_W-1:0] rdWordB
);
  logic [WORD_W-1:0] regs [NUM_REGS];
  logic [IDX_W-1:0]  logIdx  [NPORT];
  logic [IDX_W-1:0]  physIdx [NPORT];

  assign logIdx[0] = rdIdxA;
  assign logIdx[1] = rdIdxB;
  assign logIdx[2] = wrIdx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rrf_map #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) u_map (
      .logIdx (logIdx[p]),
      .base   (base),
      .physIdx(physIdx[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strobe.wrFire && physIdx[2] != '0) begin
      regs[physIdx[2]] <= wrWord;
    end
  end

  assign rdWordA = (physIdx[0] == '0) ? '0 : regs[physIdx[0]];
  assign rdWordB = (physIdx[1] == '0) ? '0 : regs[physIdx[1]];

  a_r3_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxA == '0) |-> rdWordA == '0);

  a_r3_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxB == '0) |-> rdWordB == '0);

  a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrFire && !strobe.rotFire && !strobe.clrFire) ##1 (rdIdxA == $past(wrIdx))
      |-> rdWordA == $past(wrWord));
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rrf_pkg::*;
#(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  parameter int DATA_W     = 64,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ROT_N  = NUM_REGS - NUM_STATIC,
  localparam int BASE_W = $clog2(ROT_N),
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdNatA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdNatB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrNat,
  input  logic              rotate,
  input  logic              clearBase
);
  ctrlStrobe_t       strobe;
  logic [BASE_W-1:0] base;
  logic [WORD_W-1:0] rdWordA, rdWordB;

  rrf_ctrl #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .rotate   (rotate),
    .clearBase(clearBase),
    .strobe   (strobe),
    .base     (base)
  );

  rrf_datapath #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .base   (base),
    .rdIdxA (rdIdxA),
    .rdIdxB (rdIdxB),
    .wrIdx  (wrIdx),
    .wrWord ({wrNat, wrData}),
    .rdWordA(rdWordA),
    .rdWordB(rdWordB)
  );

  assign {rdNatA, rdDataA} = rdWordA;
  assign {rdNatB, rdDataB} = rdWordB;
endmodule

// File: tb/rot_regfile_tb.sv
module rot_regfile_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  rdIdxA = 0, rdIdxB = 0, wrIdx = 0;
  logic [63:0] rdDataA, rdDataB, wrData = 0;
  logic        rdNatA, rdNatB, wrNat = 0;
  logic        wrEn = 0, rotate = 0, clearBase = 0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rot_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdNatA(rdNatA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB), .rdNatB(rdNatB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .wrNat(wrNat),
    .rotate(rotate), .clearBase(clearBase)
  );

  task automatic check(string req, logic [64:0] got, logic [64:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic readA(input logic [6:0] idx, output logic [64:0] w);
    rdIdxA = idx;
    #1;
    w = {rdNatA, rdDataA};
  endtask

  task automatic doWrite(logic [6:0] idx, logic [63:0] d, logic n, logic rot);
    @(negedge clk);
    wrEn = 1; wrIdx = idx; wrData = d; wrNat = n; rotate = rot;
    @(negedge clk);
    wrEn = 0; rotate = 0;
  endtask

  task automatic doRotate(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rotate = 1;
      @(negedge clk); rotate = 0;
    end
  endtask

  task automatic doClear(logic withRotate);
    @(negedge clk); clearBase = 1; rotate = withRotate;
    @(negedge clk); clearBase = 0; rotate = 0;
  endtask

  task automatic t_reset();
    logic [64:0] w;
    readA(7'd0, w);   check("R1 reset reg0", w, '0);
    readA(7'd31, w);  check("R1 reset reg31", w, '0);
    readA(7'd127, w); check("R1 reset reg127", w, '0);
    doWrite(7'd45, 64'h45, 0, 0);
    readA(7'd45, w);  check("R1 identity at base 0", w, {1'b0, 64'h45});
  endtask

  task automatic t_zero();
    logic [64:0] w;
    doWrite(7'd0, 64'hDEAD_BEEF, 1, 0);
    readA(7'd0, w); check("R3 reg0 port A", w, '0);
    rdIdxB = 0; #1;
    check("R3 reg0 port B", {rdNatB, rdDataB}, '0);
  endtask

  task automatic t_static();
    logic [64:0] w;
    doWrite(7'd5, 64'h1234_5678_9ABC_DEF0, 1, 0);
    doRotate(3);
    readA(7'd5, w); check("R2 static after rotate", w, {1'b1, 64'h1234_5678_9ABC_DEF0});
    check("R4 tag stored", {64'd0, w[64]}, 65'd1);
  endtask

  task automatic t_rotOne();
    logic [64:0] w;
    doClear(0);
    doWrite(7'd40, 64'hA40, 1, 0);
    doRotate(1);
    readA(7'd41, w); check("R5 X to X+1", w, {1'b1, 64'hA40});
  endtask

  task automatic t_wrap();
    logic [64:0] w;
    doClear(0);
    doWrite(7'd127, 64'hF127, 0, 0);
    doRotate(1);
    readA(7'd32, w); check("R6 wrap 127 to 32", w, {1'b0, 64'hF127});
  endtask

  task automatic t_multi();
    logic [64:0] w;
    doClear(0);
    doWrite(7'd50, 64'h5050, 0, 0);
    doRotate(10);
    readA(7'd60, w); check("R7 ten rotations", w, {1'b0, 64'h5050});
    doRotate(86);
    readA(7'd50, w); check("R7 full cycle of 96", w, {1'b0, 64'h5050});
  endtask

  task automatic t_clear();
    logic [64:0] w;
    doClear(0);
    doWrite(7'd70, 64'h7070, 1, 0);
    doRotate(7);
    doClear(0);
    readA(7'd70, w); check("R8 clear restores base", w, {1'b1, 64'h7070});
    doClear(1);
    readA(7'd70, w); check("R8 clear beats rotate", w, {1'b1, 64'h7070});
  endtask

  task automatic t_wrRot();
    logic [64:0] w;
    doClear(0);
    doWrite(7'd80, 64'h8080, 0, 1);
    readA(7'd81, w); check("R9 write uses old base", w, {1'b0, 64'h8080});
  endtask

  task automatic t_bypass();
    logic [64:0] w;
    doClear(0);
    doWrite(7'd90, 64'h1111, 0, 0);
    @(negedge clk);
    wrEn = 1; wrIdx = 7'd90; wrData = 64'h2222; wrNat = 1;
    readA(7'd90, w); check("R10 old value in write cycle", w, {1'b0, 64'h1111});
    @(negedge clk);
    wrEn = 0;
    readA(7'd90, w); check("R10 new value next cycle", w, {1'b1, 64'h2222});
  endtask

  task automatic t_dual();
    doWrite(7'd12, 64'hC12, 0, 0);
    doWrite(7'd100, 64'hD100, 1, 0);
    rdIdxA = 7'd12; rdIdxB = 7'd100; #1;
    check("R11 port A", {rdNatA, rdDataA}, {1'b0, 64'hC12});
    check("R11 port B", {rdNatB, rdDataB}, {1'b1, 64'hD100});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero();
    t_static();
    t_rotOne();
    t_wrap();
    t_multi();
    t_clear();
    t_wrRot();
    t_bypass();
    t_dual();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule